// File: doc/BRIEF.md
# Cuckoo Tag Relocation Controller

This controller runs one relocation episode when a line must be installed in a two-skew tag store and the indexed set in each skew has no free entry. It picks a resident entry at random from the eight-or-so slots of those two sets. It asks an external hashing unit for that entry's set in the opposite skew and reads that set. If the set has a free way, the controller moves the entry there. The slot the entry left is then handed to the incoming line, so no tag is evicted from its own set.

When the alternative set is also full, the controller tries another candidate that it has not tried before in the same episode. The number of tries has an upper bound. If every try fails, it reports a same-set eviction to the requester. All movement is inside the tag store: an entry keeps its data pointer, domain and dirty state, and only its skew and set position change. The tag store is reached through a combinational read port and a single write port. Two free-running counters, one for moves and one for failed episodes, are exposed.

Top module: `cuckoo_reloc`

## Requirements
- R1: A `start` while idle begins an episode only when `full0` and `full1` are both high. Otherwise it is ignored: `busy` stays low, no hash request or tag write is made, and no outcome pulse appears.
- R2: Every candidate is a valid entry taken from skew 0 at `setIdx0` or skew 1 at `setIdx1`, the two indices latched at the start of the episode.
- R3: A hash request carries the candidate's tag and domain, with `hashSkew` set to the skew opposite the candidate's. `hashReq` and `hashTag` hold steady until `hashAck`.
- R4: When the alternative set has a free way, the candidate's entry is written to the lowest-numbered free way of that set. The written entry is the original entry with valid = 1, and its data pointer, domain, dirty bit and tag are unchanged. Entry word layout: valid bit 17, domain bits 16:15, dirty bit 14, data pointer bits 13:8, tag bits 7:0.
- R5: In the cycle after the move write, the candidate's old slot is written with an all-zero entry. In that same cycle `relocOk` pulses and `freeSkew`/`freeSet`/`freeWay` name that slot.
- R6: When the alternative set is full, the next candidate is one not yet tried in the current episode.
- R7: After `MAX_TRIES` (default 3) failed tries, `relocFail` pulses. Exactly `MAX_TRIES` hash requests were made, and the episode wrote nothing to the tag store.
- R8: Each episode ends with exactly one pulse, either `relocOk` or `relocFail`, never both, and `busy` is low in the following cycle.
- R9: `relocCount` increments by one after each `relocOk`, and `failCount` increments by one after each `relocFail`.
- R10: After reset the controller is idle, both counters are zero, and no hash request, tag write or outcome pulse is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Install request needing a free slot |
| full0 | input | 1 | Indexed set in skew 0 has no free way |
| full1 | input | 1 | Indexed set in skew 1 has no free way |
| setIdx0 | input | SET_W | Incoming line's set in skew 0 |
| setIdx1 | input | SET_W | Incoming line's set in skew 1 |
| busy | output | 1 | Episode in progress |
| tsRdReq | output | 1 | Tag-store read strobe |
| tsRdSkew | output | 1 | Read skew |
| tsRdSet | output | SET_W | Read set |
| tsRdWay | output | WAY_W | Read way |
| tsRdEntry | input | ENTRY_W | Entry at the read address (same cycle) |
| tsRdValid | input | WAYS | Valid bits of every way in the read set |
| tsWr | output | 1 | Tag-store write strobe |
| tsWrSkew | output | 1 | Write skew |
| tsWrSet | output | SET_W | Write set |
| tsWrWay | output | WAY_W | Write way |
| tsWrEntry | output | ENTRY_W | Entry written |
| hashReq | output | 1 | Alternative-index request |
| hashSkew | output | 1 | Skew the index is wanted for |
| hashTag | output | TAG_W | Candidate tag |
| hashDom | output | DOM_W | Candidate domain |
| hashAck | input | 1 | Index valid |
| hashIdx | input | SET_W | Alternative set index |
| relocOk | output | 1 | Move done, slot freed |
| relocFail | output | 1 | All tries failed; same-set eviction needed |
| freeSkew | output | 1 | Skew of freed slot |
| freeSet | output | SET_W | Set of freed slot |
| freeWay | output | WAY_W | Way of freed slot |
| relocCount | output | CNT_W | Successful moves |
| failCount | output | CNT_W | Failed episodes |

## Verification
A corrupted latched candidate shows up at the ports within a few cycles. It appears as a hash request for a tag that does not belong to either indexed set, or as a move whose written entry differs from the original in some field. A broken tried-mask or try counter appears at the end of the episode, as a repeated tag among the hash requests or as a wrong number of requests before `relocFail`. A wrong free-way choice or a wrong freed-slot report is caught in the outcome cycle itself, by comparing against a snapshot of the tag store taken before the episode.

// File: rtl/cuckoo_pkg.sv
package cuckoo_pkg;
  localparam int TAG_W  = 8;
  localparam int FPTR_W = 6;
  localparam int DOM_W  = 2;

  typedef struct packed {
    logic              valid;
    logic [DOM_W-1:0]  dom;
    logic              dirty;
    logic [FPTR_W-1:0] fptr;
    logic [TAG_W-1:0]  tag;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PICK, ST_HASH, ST_CHECK, ST_MOVE, ST_DONE, ST_FAIL
  } state_t;

  typedef struct packed {
    logic beginEp;
    logic pickCand;
    logic takeAlt;
    logic rdAlt;
    logic takeFree;
    logic wrMove;
    logic wrClear;
    logic okPulse;
    logic failPulse;
  } strobe_t;
endpackage

// File: rtl/cuckoo_reloc_ctrl.sv
module cuckoo_reloc_ctrl
  import cuckoo_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    full0,
  input  logic    full1,
  input  logic    hashAck,
  input  logic    altFree,
  input  logic    lastTry,
  output strobe_t stb,
  output logic    busy,
  output logic    hashReq
);
  state_t state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    unique case (state)
      ST_IDLE:  if (start && full0 && full1) begin
                  stb.beginEp = 1'b1;
                  nxt = ST_PICK;
                end
      ST_PICK:  begin
                  stb.pickCand = 1'b1;
                  nxt = ST_HASH;
                end
      ST_HASH:  if (hashAck) begin
                  stb.takeAlt = 1'b1;
                  nxt = ST_CHECK;
                end
      ST_CHECK: begin
                  stb.rdAlt = 1'b1;
                  if (altFree) begin
                    stb.takeFree = 1'b1;
                    nxt = ST_MOVE;
                  end else if (lastTry) nxt = ST_FAIL;
                  else                  nxt = ST_PICK;
                end
      ST_MOVE:  begin
                  stb.wrMove = 1'b1;
                  nxt = ST_DONE;
                end
      ST_DONE:  begin
                  stb.wrClear = 1'b1;
                  stb.okPulse = 1'b1;
                  nxt = ST_IDLE;
                end
      ST_FAIL:  begin
                  stb.failPulse = 1'b1;
                  nxt = ST_IDLE;
                end
      default:  nxt = ST_IDLE;
    endcase
  end

  assign busy    = (state != ST_IDLE);
  assign hashReq = (state == ST_HASH);
endmodule

// File: rtl/cuckoo_reloc_dp.sv
module cuckoo_reloc_dp
  import cuckoo_pkg::*;
#(
  parameter int SETS      = 8,
  parameter int WAYS      = 4,
  parameter int MAX_TRIES = 3,
  parameter int CNT_W     = 16,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [SET_W-1:0]  setIdx0,
  input  logic [SET_W-1:0]  setIdx1,
  input  entry_t            tsRdEntry,
  input  logic [WAYS-1:0]   tsRdValid,
  input  logic [SET_W-1:0]  hashIdx,
  output logic              tsRdSkew,
  output logic [SET_W-1:0]  tsRdSet,
  output logic [WAY_W-1:0]  tsRdWay,
  output logic              tsWrSkew,
  output logic [SET_W-1:0]  tsWrSet,
  output logic [WAY_W-1:0]  tsWrWay,
  output entry_t            tsWrEntry,
  output logic              hashSkew,
  output logic [TAG_W-1:0]  hashTag,
  output logic [DOM_W-1:0]  hashDom,
  output logic              freeSkew,
  output logic [SET_W-1:0]  freeSet,
  output logic [WAY_W-1:0]  freeWay,
  output logic              altFree,
  output logic              lastTry,
  output logic [CNT_W-1:0]  relocCount,
  output logic [CNT_W-1:0]  failCount
);
  localparam int CODE_W = WAY_W + 1;
  localparam int SLOTS  = 2 * WAYS;
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);

  logic [1:0][SET_W-1:0] idxReg;
  logic                  candSkew;
  logic [WAY_W-1:0]      candWay;
  entry_t                candEntry;
  logic [SET_W-1:0]      altIdx;
  logic [WAY_W-1:0]      altWay;
  logic [SLOTS-1:0]      tried;
  logic [TRY_W-1:0]      tries;
  logic [15:0]           lfsr;
  logic [CODE_W-1:0]     startCode, probe, pickCode;
  logic [WAY_W-1:0]      firstFree;

  // random start point, then first untried slot scanning upward (wraps)
  assign startCode = lfsr[CODE_W-1:0];
  always_comb begin
    pickCode = startCode;
    probe    = startCode;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      probe = startCode + CODE_W'(k);
      if (!tried[probe]) pickCode = probe;
    end
  end

  always_comb begin
    firstFree = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!tsRdValid[w]) firstFree = WAY_W'(w);
  end

  assign altFree = ~&tsRdValid;
  assign lastTry = (tries == TRY_W'(MAX_TRIES));

  assign tsRdSkew = stb.rdAlt ? ~candSkew : pickCode[CODE_W-1];
  assign tsRdSet  = stb.rdAlt ? altIdx : idxReg[pickCode[CODE_W-1]];
  assign tsRdWay  = stb.rdAlt ? '0 : pickCode[WAY_W-1:0];

  always_comb begin
    tsWrSkew  = candSkew;
    tsWrSet   = idxReg[candSkew];
    tsWrWay   = candWay;
    tsWrEntry = '0;
    if (stb.wrMove) begin
      tsWrSkew        = ~candSkew;
      tsWrSet         = altIdx;
      tsWrWay         = altWay;
      tsWrEntry       = candEntry;
      tsWrEntry.valid = 1'b1;
    end
  end

  assign hashSkew = ~candSkew;
  assign hashTag  = candEntry.tag;
  assign hashDom  = candEntry.dom;
  assign freeSkew = candSkew;
  assign freeSet  = idxReg[candSkew];
  assign freeWay  = candWay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxReg     <= '0;
      candSkew   <= 1'b0;
      candWay    <= '0;
      candEntry  <= '0;
      altIdx     <= '0;
      altWay     <= '0;
      tried      <= '0;
      tries      <= '0;
      lfsr       <= SEED;
      relocCount <= '0;
      failCount  <= '0;
    end else begin
      lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      if (stb.beginEp) begin
        idxReg[0] <= setIdx0;
        idxReg[1] <= setIdx1;
        tried     <= '0;
        tries     <= '0;
      end
      if (stb.pickCand) begin
        candSkew        <= pickCode[CODE_W-1];
        candWay         <= pickCode[WAY_W-1:0];
        candEntry       <= tsRdEntry;
        tried[pickCode] <= 1'b1;
        tries           <= tries + TRY_W'(1);
      end
      if (stb.takeAlt)   altIdx     <= hashIdx;
      if (stb.takeFree)  altWay     <= firstFree;
      if (stb.okPulse)   relocCount <= relocCount + CNT_W'(1);
      if (stb.failPulse) failCount  <= failCount + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cuckoo_reloc.sv
module cuckoo_reloc
  import cuckoo_pkg::*;
#(
  parameter int SETS      = 8,
  parameter int WAYS      = 4,
  parameter int MAX_TRIES = 3,
  parameter int CNT_W     = 16,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               full0,
  input  logic               full1,
  input  logic [SET_W-1:0]   setIdx0,
  input  logic [SET_W-1:0]   setIdx1,
  output logic               busy,
  output logic               tsRdReq,
  output logic               tsRdSkew,
  output logic [SET_W-1:0]   tsRdSet,
  output logic [WAY_W-1:0]   tsRdWay,
  input  logic [ENTRY_W-1:0] tsRdEntry,
  input  logic [WAYS-1:0]    tsRdValid,
  output logic               tsWr,
  output logic               tsWrSkew,
  output logic [SET_W-1:0]   tsWrSet,
  output logic [WAY_W-1:0]   tsWrWay,
  output logic [ENTRY_W-1:0] tsWrEntry,
  output logic               hashReq,
  output logic               hashSkew,
  output logic [TAG_W-1:0]   hashTag,
  output logic [DOM_W-1:0]   hashDom,
  input  logic               hashAck,
  input  logic [SET_W-1:0]   hashIdx,
  output logic               relocOk,
  output logic               relocFail,
  output logic               freeSkew,
  output logic [SET_W-1:0]   freeSet,
  output logic [WAY_W-1:0]   freeWay,
  output logic [CNT_W-1:0]   relocCount,
  output logic [CNT_W-1:0]   failCount
);
  strobe_t stb;
  logic    altFree, lastTry;
  entry_t  wrEntry;

  cuckoo_reloc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .full0(full0), .full1(full1),
    .hashAck(hashAck), .altFree(altFree), .lastTry(lastTry),
    .stb(stb), .busy(busy), .hashReq(hashReq)
  );

  cuckoo_reloc_dp #(
    .SETS(SETS), .WAYS(WAYS), .MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W), .SEED(SEED)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .setIdx0(setIdx0), .setIdx1(setIdx1),
    .tsRdEntry(entry_t'(tsRdEntry)), .tsRdValid(tsRdValid), .hashIdx(hashIdx),
    .tsRdSkew(tsRdSkew), .tsRdSet(tsRdSet), .tsRdWay(tsRdWay),
    .tsWrSkew(tsWrSkew), .tsWrSet(tsWrSet), .tsWrWay(tsWrWay), .tsWrEntry(wrEntry),
    .hashSkew(hashSkew), .hashTag(hashTag), .hashDom(hashDom),
    .freeSkew(freeSkew), .freeSet(freeSet), .freeWay(freeWay),
    .altFree(altFree), .lastTry(lastTry),
    .relocCount(relocCount), .failCount(failCount)
  );

  assign tsWrEntry = wrEntry;
  assign tsRdReq   = stb.pickCand | stb.rdAlt;
  assign tsWr      = stb.wrMove | stb.wrClear;
  assign relocOk   = stb.okPulse;
  assign relocFail = stb.failPulse;
endmodule

// File: rtl/cuckoo_reloc_chk.sv
module cuckoo_reloc_chk
  import cuckoo_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               full0,
  input logic               full1,
  input logic               busy,
  input logic               tsWr,
  input logic [ENTRY_W-1:0] tsWrEntry,
  input logic               hashReq,
  input logic               hashAck,
  input logic [TAG_W-1:0]   hashTag,
  input logic               relocOk,
  input logic               relocFail,
  input logic [CNT_W-1:0]   relocCount,
  input logic [CNT_W-1:0]   failCount
);
  // R1
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !(full0 && full1)) |=> !busy);

  // R3
  hash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hashReq && !hashAck) |=> (hashReq && $stable(hashTag)));

  // R5
  move_then_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsWr && tsWrEntry[ENTRY_W-1]) |=> (relocOk && tsWr && !tsWrEntry[ENTRY_W-1]));

  // R7
  fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    relocFail |-> !tsWr);

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(relocOk && relocFail));

  // R8
  idle_after_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (relocOk || relocFail) |=> !busy);

  // R9
  reloc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    relocOk |=> (relocCount == $past(relocCount) + CNT_W'(1)));

  // R9
  fail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    relocFail |=> (failCount == $past(failCount) + CNT_W'(1)));
endmodule

bind cuckoo_reloc cuckoo_reloc_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/cuckoo_reloc_test.sv
`timescale 1ns/1ps
module cuckoo_reloc_test;
  import cuckoo_pkg::*;
  localparam int SETS = 8, WAYS = 4, SET_W = 3, WAY_W = 2, CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 0, full0 = 0, full1 = 0;
  logic [SET_W-1:0] setIdx0 = '0, setIdx1 = '0;
  logic busy, tsRdReq, tsRdSkew, tsWr, tsWrSkew, hashReq, hashSkew;
  logic [SET_W-1:0] tsRdSet, tsWrSet, freeSet;
  logic [WAY_W-1:0] tsRdWay, tsWrWay, freeWay;
  entry_t rdE, wrE;
  logic [WAYS-1:0] rdMask;
  logic [TAG_W-1:0] hashTag;
  logic [DOM_W-1:0] hashDom;
  logic hashAck = 0;
  logic [SET_W-1:0] hashIdx = '0;
  logic relocOk, relocFail, freeSkew;
  logic [CNT_W-1:0] relocCount, failCount;

  cuckoo_reloc uut (
    .clk(clk), .rst_n(rst_n), .start(start), .full0(full0), .full1(full1),
    .setIdx0(setIdx0), .setIdx1(setIdx1), .busy(busy), .tsRdReq(tsRdReq),
    .tsRdSkew(tsRdSkew), .tsRdSet(tsRdSet), .tsRdWay(tsRdWay),
    .tsRdEntry(rdE), .tsRdValid(rdMask), .tsWr(tsWr), .tsWrSkew(tsWrSkew),
    .tsWrSet(tsWrSet), .tsWrWay(tsWrWay), .tsWrEntry(wrE),
    .hashReq(hashReq), .hashSkew(hashSkew), .hashTag(hashTag), .hashDom(hashDom),
    .hashAck(hashAck), .hashIdx(hashIdx), .relocOk(relocOk), .relocFail(relocFail),
    .freeSkew(freeSkew), .freeSet(freeSet), .freeWay(freeWay),
    .relocCount(relocCount), .failCount(failCount)
  );

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [SET_W-1:0] hashOf(input logic [TAG_W-1:0] t, input logic s);
    return s ? t[5:3] : t[2:0];
  endfunction

  // tag-store model, single owner process
  entry_t mem  [2][SETS][WAYS];
  entry_t snap [2][SETS][WAYS];
  logic loadReq = 0;
  int   loadKind = 0;

  always_comb begin
    rdE = mem[tsRdSkew][tsRdSet][tsRdWay];
    for (int w = 0; w < WAYS; w++) rdMask[w] = mem[tsRdSkew][tsRdSet][w].valid;
  end

  always @(posedge clk) begin
    if (loadReq) begin
      for (int s = 0; s < 2; s++)
        for (int t = 0; t < SETS; t++)
          for (int w = 0; w < WAYS; w++) begin
            entry_t e;
            e = '0;
            if (t == 0) begin
              e.valid = 1'b1;
              e.dom   = s ? 2'(3 - w) : 2'(w);
              e.dirty = s ? ~w[0] : w[0];
              e.fptr  = s ? 6'(40 + w) : 6'(10 + w);
              e.tag   = s ? {2'd1, 3'd0, 3'(w + 1)} : {2'd0, 3'(w + 1), 3'd0};
            end else if ((loadKind == 1 && t <= 4) || (loadKind == 2 && s == 1 && t == 1)) begin
              e.valid = 1'b1;
              e.tag   = {2'd3, 3'(t), 3'(w)};
              e.fptr  = 6'(w);
            end
            mem[s][t][w] <= e;
          end
    end else if (tsWr) begin
      mem[tsWrSkew][tsWrSet][tsWrWay] <= wrE;
    end
  end

  // hash responder: answers after two cycles of request
  int hWait = 0;
  initial forever begin
    @(negedge clk);
    if (hashAck) hashAck = 0;
    else if (hashReq) begin
      if (hWait == 1) begin
        hashAck = 1;
        hashIdx = hashOf(hashTag, hashSkew);
        hWait = 0;
      end else hWait++;
    end
  end

  // scoreboard
  bit expQ[$];
  bit blockedOn = 0;
  logic [TAG_W-1:0] blockedTag = 8'h08;
  logic [TAG_W-1:0] triedTag [8];
  int nTry = 0, wrCount = 0;
  bit haveMove = 0;
  logic mvSkew;
  logic [SET_W-1:0] mvSet;
  logic [WAY_W-1:0] mvWay;
  entry_t mvEntry;

  function automatic int lowestFree(input logic s, input logic [SET_W-1:0] t);
    for (int w = 0; w < WAYS; w++) if (!snap[s][t][w].valid) return w;
    return -1;
  endfunction

  initial forever begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (tsWr) wrCount++;
      if (hashReq && hashAck) begin
        bit found = 0;
        for (int s = 0; s < 2; s++)
          for (int w = 0; w < WAYS; w++) begin
            entry_t e;
            e = snap[s][s ? setIdx1 : setIdx0][w];
            if (e.valid && e.tag == hashTag && e.dom == hashDom && hashSkew == !s[0]) found = 1;
          end
        check(found, "R2/R3 hash request names a candidate of the indexed sets", hashTag, 0);
        for (int i = 0; i < nTry; i++)
          check(triedTag[i] != hashTag, "R6 candidate repeated", hashTag, triedTag[i]);
        if (nTry < 8) triedTag[nTry] = hashTag;
        nTry++;
      end
      if (tsWr && wrE.valid) begin
        haveMove = 1; mvSkew = tsWrSkew; mvSet = tsWrSet; mvWay = tsWrWay; mvEntry = wrE;
      end
      if (relocOk || relocFail) begin
        if (expQ.size() == 0) check(0, "R8 unexpected outcome pulse", relocOk, 0);
        else begin
          bit exp;
          exp = expQ.pop_front();
          check(relocOk == exp && relocFail == !exp, "R8 outcome kind", relocOk, exp);
          if (relocOk) begin
            entry_t orig;
            orig = snap[freeSkew][freeSet][freeWay];
            check(freeSet == (freeSkew ? setIdx1 : setIdx0), "R2 freed slot in indexed set", freeSet, 0);
            check(haveMove, "R4 move write seen", haveMove, 1);
            check(mvEntry == orig, "R4 fields kept", mvEntry, orig);
            check(mvSkew == !freeSkew, "R4 opposite skew", mvSkew, !freeSkew);
            check(mvSet == hashOf(orig.tag, mvSkew), "R4 alternative set", mvSet, hashOf(orig.tag, mvSkew));
            check(int'(mvWay) == lowestFree(mvSkew, mvSet), "R4 lowest free way", mvWay, lowestFree(mvSkew, mvSet));
            check(tsWr && wrE == '0 && tsWrSkew == freeSkew && tsWrSet == freeSet && tsWrWay == freeWay,
                  "R5 old slot cleared", {tsWr, tsWrSkew, tsWrSet, tsWrWay}, {1'b1, freeSkew, freeSet, freeWay});
            if (blockedOn) check(orig.tag != blockedTag, "R6 blocked candidate not moved", orig.tag, blockedTag);
          end else begin
            check(!haveMove, "R7 no move on failure", haveMove, 0);
            check(nTry == 3, "R7 try count", nTry, 3);
          end
        end
        nTry = 0; haveMove = 0;
      end
    end
  end

  task automatic finishRun();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog: episode did not end, actual 0 expected 1");
    finishRun();
  end

  task automatic runEp(input int kind, input bit expOk);
    logic [CNT_W-1:0] r0, f0;
    loadKind = kind;
    blockedOn = (kind == 2);
    @(negedge clk) loadReq = 1;
    @(negedge clk) loadReq = 0;
    @(negedge clk);
    for (int s = 0; s < 2; s++)
      for (int t = 0; t < SETS; t++)
        for (int w = 0; w < WAYS; w++) snap[s][t][w] = mem[s][t][w];
    r0 = relocCount; f0 = failCount;
    expQ.push_back(expOk);
    start = 1; full0 = 1; full1 = 1;
    @(negedge clk);
    start = 0;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk); #1;
    check(!busy, "R8 idle after outcome", busy, 0);
    check(relocCount == r0 + CNT_W'(expOk), "R9 relocation counter", relocCount, r0 + CNT_W'(expOk));
    check(failCount == f0 + CNT_W'(!expOk), "R9 failure counter", failCount, f0 + CNT_W'(!expOk));
  endtask

  task automatic ignoredStart(input logic a, input logic b);
    int w0;
    logic [CNT_W-1:0] r0, f0;
    w0 = wrCount; r0 = relocCount; f0 = failCount;
    start = 1; full0 = a; full1 = b;
    @(negedge clk);
    start = 0;
    repeat (10) begin
      @(negedge clk); #1;
      check(!busy && !hashReq, "R1 start ignored", {busy, hashReq}, 0);
    end
    check(wrCount == w0 && relocCount == r0 && failCount == f0, "R1 no write or outcome",
          wrCount - w0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !tsWr && !hashReq && !relocOk && !relocFail, "R10 outputs in reset",
          {busy, tsWr, hashReq, relocOk, relocFail}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    check(relocCount == 0 && failCount == 0, "R10 counters zero", {relocCount, failCount}, 0);
    check(!busy && !tsWr && !hashReq, "R10 idle after reset", {busy, tsWr, hashReq}, 0);

    // both sets loaded full so only the flags decide
    loadKind = 0;
    @(negedge clk) loadReq = 1;
    @(negedge clk) loadReq = 0;
    ignoredStart(1, 0);
    ignoredStart(0, 1);
    ignoredStart(0, 0);

    repeat (5) runEp(0, 1);   // R4 R5: every alternative set has room
    repeat (3) runEp(1, 0);   // R7: every alternative set full
    repeat (5) runEp(2, 1);   // R6: one candidate blocked, retry succeeds
    ignoredStart(1, 0);
    runEp(1, 0);
    runEp(0, 1);

    finishRun();
  end
endmodule